// File: doc/BRIEF.md
# Programmable Synthesizer Divider Chain

This block holds the digital counters of a UHF frequency synthesizer. On the reference side it divides a 4 MHz crystal clock by 128. This yields one comparison pulse per 31.25 kHz period. The same counter also produces a sound-reference tick, at either 31.25 kHz or 62.5 kHz. On the oscillator side it takes a clock at twice the RF carrier, divides it by 16 (a halving followed by a divide-by-eight), and then divides it by a 12-bit programmable value N. This returns a feedback pulse at the same 31.25 kHz rate when the carrier sits at N × 250 kHz.

The divide value can be rewritten at any time. A zero value is refused. An accepted value takes effect only when the feedback counter wraps, so the feedback pulse train never carries a truncated or stretched period. A separate output stage passes the oscillator clock straight through, or divides it by 2, 4, 8 or 16 for use in the VHF band. The phase comparator and the oscillator are outside this block.

Top module: `synth_divider_chain`

## Requirements
- R1: `ref_pulse` is high for exactly one `ref_clk` cycle in every 128 `ref_clk` cycles.
- R2: With `srf_fast` = 0, `sound_tick` repeats every 128 `ref_clk` cycles and coincides with `ref_pulse`. With `srf_fast` = 1, it repeats every 64 cycles. Every tick is one cycle wide.
- R3: `fb_pulse` is high for one `vco_clk` cycle and repeats every 16 × N `vco_clk` cycles, where N is the active divide value (1 to 4095).
- R4: After reset the active N is 2365 (591.25 MHz / 250 kHz). The first `fb_pulse` appears 16 × 2365 − 1 `vco_clk` rising edges after the first edge with `rst_n` high.
- R5: A write (`n_write` = 1) with `n_value` = 0 is ignored. The period stays at the previously programmed N, and the active N is never zero.
- R6: A nonzero value written in the middle of a feedback period does not change that period. The new value sets the length of the next period. A write in the same cycle as the terminal count sets the very next period.
- R7: `vhf_sel` codes 1, 2, 3 and 4 make `out_clk` the oscillator clock divided by 2, 4, 8 and 16. Code 0 and codes 5 to 7 pass `vco_clk` through unchanged.
- R8: While `rst_n` is low at the clock edges, `ref_pulse`, `sound_tick` and `fb_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | 4 MHz crystal reference clock |
| vco_clk | input | 1 | Oscillator-derived clock at twice the carrier |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| n_value | input | 12 | Divide value in 250 kHz steps, `vco_clk` domain |
| n_write | input | 1 | Write strobe for `n_value` |
| srf_fast | input | 1 | 1 selects a 62.5 kHz sound reference, 0 selects 31.25 kHz |
| vhf_sel | input | 3 | Output divider select |
| ref_pulse | output | 1 | Reference comparison pulse |
| fb_pulse | output | 1 | Feedback comparison pulse |
| sound_tick | output | 1 | Sound reference tick |
| out_clk | output | 1 | Oscillator clock, passed through or divided |

## Verification
A divide-value write can land in the same `vco_clk` cycle as the feedback terminal count. Those two functions then compete for the register that sets the next period. The bench provokes this by watching for `fb_pulse` and driving `n_write` at once, so the write is sampled on the very edge that wraps the counter. It then judges the result by counting the cycles to the next pulse, which must be 16 times the newly written value for every N from 1 to 12. On the reference side, the 31.25 kHz sound tick and the comparison pulse fall in one cycle, and the bench checks that they coincide at each tick.

// File: rtl/synth_div_pkg.sv
// Package: shared constants and the output-divider code decode for the
// synthesizer divider chain. Assumes exactly four VHF halving stages.
package synth_div_pkg;

    localparam int unsigned VHF_STAGE_COUNT = 4;

    typedef enum logic [2:0] {
        VHF_PASS  = 3'd0,
        VHF_DIV2  = 3'd1,
        VHF_DIV4  = 3'd2,
        VHF_DIV8  = 3'd3,
        VHF_DIV16 = 3'd4
    } vhf_code_e;

    // Map a select code to the number of halving stages; unknown codes bypass.
    function automatic logic [2:0] vhf_stage_of(input logic [2:0] code);
        logic [2:0] stage;
        case (code)
            VHF_DIV2:  stage = 3'd1;
            VHF_DIV4:  stage = 3'd2;
            VHF_DIV8:  stage = 3'd3;
            VHF_DIV16: stage = 3'd4;
            default:   stage = 3'd0;
        endcase
        return stage;
    endfunction

endpackage

// File: rtl/ref_divider.sv
// Module: ref_divider
// Divides the crystal clock by REF_DIV to produce the comparison pulse, and
// taps the same counter for the sound reference tick at the full or half
// period. Assumes REF_DIV is a power of two of at least 4.
module ref_divider #(
    parameter int unsigned REF_DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srf_fast,
    output logic ref_pulse,
    output logic sound_tick
);
    localparam int unsigned CW = $clog2(REF_DIV);
    localparam int unsigned SW = CW - 1;

    logic [CW-1:0] ref_cnt;
    logic          half_tc;

    // Free-running reference counter with a wrap at REF_DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_cnt <= '0;
        else if (ref_cnt == CW'(REF_DIV - 1))
            ref_cnt <= '0;
        else
            ref_cnt <= ref_cnt + CW'(1);
    end

    // Terminal-count decodes for the full and the half period.
    always_comb begin
        ref_pulse  = (ref_cnt == CW'(REF_DIV - 1));
        half_tc    = (ref_cnt[SW-1:0] == {SW{1'b1}});
        sound_tick = srf_fast ? half_tc : ref_pulse;
    end

    assert_ref_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);
    assert_sound_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sound_tick |=> !sound_tick);
    assert_sound_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |-> sound_tick);

endmodule

// File: rtl/fb_divider.sv
// Module: fb_divider
// Prescales the oscillator clock by PRESCALE (halving then divide-by-eight,
// merged into one counter) and counts prescaled ticks up to the active N.
// Holds a pending N that is loaded at terminal count; zero writes are dropped.
// Assumes n_value and n_write are synchronous to clk.
module fb_divider #(
    parameter int unsigned PRESCALE  = 16,
    parameter int unsigned N_W       = 12,
    parameter int unsigned DEFAULT_N = 2365
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_value,
    input  logic           n_write,
    output logic           fb_pulse
);
    localparam int unsigned PW = $clog2(PRESCALE);

    logic [PW-1:0]  presc_cnt;
    logic [N_W-1:0] prog_cnt;
    logic [N_W-1:0] n_active;
    logic [N_W-1:0] n_pending;
    logic           presc_tc;
    logic           term;
    logic           write_ok;

    // Decode prescaler wrap, feedback terminal count and write acceptance.
    always_comb begin
        presc_tc = (presc_cnt == PW'(PRESCALE - 1));
        term     = presc_tc && (prog_cnt == n_active - N_W'(1));
        write_ok = n_write && (n_value != '0);
        fb_pulse = term;
    end

    // Fixed prescaler: one tick every PRESCALE oscillator cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            presc_cnt <= '0;
        else if (presc_tc)
            presc_cnt <= '0;
        else
            presc_cnt <= presc_cnt + PW'(1);
    end

    // Programmable counter: advances on prescaler ticks and wraps at N-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prog_cnt <= '0;
        else if (term)
            prog_cnt <= '0;
        else if (presc_tc)
            prog_cnt <= prog_cnt + N_W'(1);
    end

    // Pending divide value: captures every nonzero write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            n_pending <= N_W'(DEFAULT_N);
        else if (write_ok)
            n_pending <= n_value;
    end

    // Active divide value: reloaded only at terminal count; a write in that cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            n_active <= N_W'(DEFAULT_N);
        else if (term)
            n_active <= write_ok ? n_value : n_pending;
    end

    assert_active_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        n_active != '0);
    assert_pending_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        n_pending != '0);
    assert_reload_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(n_active) |-> $past(fb_pulse));
    assert_fb_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prog_cnt < n_active);

endmodule

// File: rtl/vhf_divider.sv
// Module: vhf_divider
// Optional output divider: a binary ripple-free counter whose stage taps are
// selected by the code; stage 0 passes the input clock through unchanged.
// Assumes sel changes rarely (a glitch on changeover is accepted).
module vhf_divider
    import synth_div_pkg::*;
#(
    parameter int unsigned STAGES = VHF_STAGE_COUNT
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       out_clk
);
    logic [STAGES-1:0] div_cnt;
    logic [STAGES:0]   taps;
    logic [2:0]        stage;

    // Halving counter feeding all stage taps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + STAGES'(1);
    end

    assign taps[0] = clk;
    for (genvar k = 1; k <= STAGES; k++) begin : g_tap
        assign taps[k] = div_cnt[k-1];
    end

    // Select the tap named by the decoded code.
    always_comb begin
        stage   = vhf_stage_of(sel);
        out_clk = taps[stage];
    end

endmodule

// File: rtl/synth_divider_chain.sv
// Module: synth_divider_chain
// Top of the synthesizer divider chain: reference divider in the crystal
// domain, feedback divider and output divider in the oscillator domain.
// Assumes rst_n is held low across several edges of both clocks.
module synth_divider_chain
    import synth_div_pkg::*;
#(
    parameter int unsigned REF_DIV   = 128,
    parameter int unsigned PRESCALE  = 16,
    parameter int unsigned N_W       = 12,
    parameter int unsigned DEFAULT_N = 2365
) (
    input  logic           ref_clk,
    input  logic           vco_clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_value,
    input  logic           n_write,
    input  logic           srf_fast,
    input  logic [2:0]     vhf_sel,
    output logic           ref_pulse,
    output logic           fb_pulse,
    output logic           sound_tick,
    output logic           out_clk
);

    ref_divider #(.REF_DIV(REF_DIV)) u_ref (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .srf_fast   (srf_fast),
        .ref_pulse  (ref_pulse),
        .sound_tick (sound_tick)
    );

    fb_divider #(
        .PRESCALE  (PRESCALE),
        .N_W       (N_W),
        .DEFAULT_N (DEFAULT_N)
    ) u_fb (
        .clk      (vco_clk),
        .rst_n    (rst_n),
        .n_value  (n_value),
        .n_write  (n_write),
        .fb_pulse (fb_pulse)
    );

    vhf_divider #(.STAGES(VHF_STAGE_COUNT)) u_vhf (
        .clk     (vco_clk),
        .rst_n   (rst_n),
        .sel     (vhf_sel),
        .out_clk (out_clk)
    );

endmodule

// File: tb/test_synth_divider_chain.sv
module test_synth_divider_chain;
    logic        ref_clk = 1'b0;
    logic        vco_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic [11:0] n_value = '0;
    logic        n_write = 1'b0;
    logic        srf_fast = 1'b0;
    logic [2:0]  vhf_sel = '0;
    logic        ref_pulse, fb_pulse, sound_tick, out_clk;

    int checks = 0;
    int fails  = 0;

    synth_divider_chain i_synth_divider_chain (
        .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n),
        .n_value(n_value), .n_write(n_write), .srf_fast(srf_fast),
        .vhf_sel(vhf_sel), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .sound_tick(sound_tick), .out_clk(out_clk)
    );

    always #4  vco_clk = ~vco_clk;
    always #16 ref_clk = ~ref_clk;

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // From a vco negedge, count negedges until fb_pulse; optional write at index wr_at.
    task automatic measure_fb(input int wr_at, input logic [11:0] val, output int cyc);
        cyc = 0;
        if (wr_at == 0) begin n_value = val; n_write = 1'b1; end
        do begin
            @(negedge vco_clk);
            cyc++;
            if (n_write) n_write = 1'b0;
            if (cyc == wr_at && wr_at > 0) begin n_value = val; n_write = 1'b1; end
        end while (!fb_pulse);
    endtask

    // From a ref negedge, count negedges until the chosen ref output is high.
    task automatic measure_ref(input bit use_sound, output int cyc);
        cyc = 0;
        do begin
            @(negedge ref_clk);
            cyc++;
        end while (!(use_sound ? sound_tick : ref_pulse));
    endtask

    initial begin
        #(190000 * 8);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int cyc;
        int trans;
        logic prev;
        // R8: outputs quiet during reset
        repeat (6) @(negedge vco_clk);
        check("R8 ref_pulse", ref_pulse, 0);
        check("R8 sound_tick", sound_tick, 0);
        check("R8 fb_pulse", fb_pulse, 0);
        rst_n = 1'b1;
        // R4: default divide value sets the first period; write N=3 mid-period
        measure_fb(5, 12'd3, cyc);
        check("R4 first feedback period", cyc, 16 * 2365 - 1);
        // R6: the mid-period write applies to the next period
        measure_fb(-1, 12'd0, cyc);
        check("R6 new N after wrap", cyc, 48);
        // R5: zero write ignored
        measure_fb(10, 12'd0, cyc);
        check("R5 zero write period", cyc, 48);
        measure_fb(-1, 12'd0, cyc);
        check("R5 period after zero write", cyc, 48);
        // R6: mid-period write of 5 leaves the running period intact
        measure_fb(10, 12'd5, cyc);
        check("R6 running period kept", cyc, 48);
        measure_fb(-1, 12'd0, cyc);
        check("R6 next period uses 5", cyc, 80);
        // R3/R6: writes coincident with the terminal count, sweep N
        for (int n = 1; n <= 12; n++) begin
            measure_fb(0, 12'(n), cyc);
            check($sformatf("R3 R6 coincident write N=%0d", n), cyc, 16 * n);
        end
        measure_fb(0, 12'd300, cyc);
        check("R3 period N=300", cyc, 4800);
        measure_fb(-1, 12'd0, cyc);
        check("R3 repeat N=300", cyc, 4800);
        // R7: output divider codes
        for (int code = 0; code < 8; code++) begin
            vhf_sel = 3'(code);
            repeat (2) @(negedge vco_clk);
            if (code >= 1 && code <= 4) begin
                trans = 0;
                prev = out_clk;
                for (int s = 0; s < 64; s++) begin
                    @(negedge vco_clk);
                    if (out_clk != prev) trans++;
                    prev = out_clk;
                end
                check($sformatf("R7 divided code %0d transitions", code), trans, 64 >> (code - 1));
            end else begin
                @(posedge vco_clk); #2;
                check($sformatf("R7 bypass code %0d high", code), out_clk, 1);
                @(negedge vco_clk); #2;
                check($sformatf("R7 bypass code %0d low", code), out_clk, 0);
            end
        end
        // R1: reference period
        measure_ref(1'b0, cyc);
        measure_ref(1'b0, cyc);
        check("R1 ref period", cyc, 128);
        measure_ref(1'b0, cyc);
        check("R1 ref period again", cyc, 128);
        // R2: slow sound tick coincides with ref pulse
        measure_ref(1'b1, cyc);
        check("R2 slow tick aligned", ref_pulse, 1);
        measure_ref(1'b1, cyc);
        check("R2 slow tick period", cyc, 128);
        check("R2 slow tick aligned again", ref_pulse, 1);
        // R2: fast sound tick
        srf_fast = 1'b1;
        measure_ref(1'b1, cyc);
        measure_ref(1'b1, cyc);
        check("R2 fast tick period", cyc, 64);
        measure_ref(1'b1, cyc);
        check("R2 fast tick period again", cyc, 64);
        @(negedge ref_clk);
        check("R2 fast tick one wide", sound_tick, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule